// File: doc/BRIEF.md
# Multi-queue shared-memory FIFO controller

This block divides one storage array into a number of independent logical FIFO queues. The storage is a pool of fixed-size allocation blocks. The queue count is a parameter from 1 to 32, and every queue receives an equal whole number of blocks. The layout is fixed from reset onward. By default there are 32 queues that together cover the whole pool.

The write port names a target queue with its own select input. The read port names a source queue with a separate select input. A write and a read can both be accepted in the same clock cycle, to the same queue or to different queues. The read side works as first-word-fall-through: the head word of the selected queue and an output-valid flag are shown directly, with no priming read.

The full and almost-full flags follow the write selection. The valid and almost-empty flags follow the read selection. On each port, an 8-bit status bus shows the almost-full (write side) or almost-empty (read side) flags of a group of eight queues. The group is picked either by an address input or by a counter that steps through the groups. A clear request empties one chosen queue and leaves every other queue alone.

Top module: `mq_fifo`

## Requirements
- R1: After reset every queue is empty. For every queue, `rd_valid`=0, `full`=0 and `almost_empty`=1. `wr_rej` and `rd_rej` are 0, and `wr_grp`/`rd_grp` read 0.
- R2: Each queue holds (TOTAL_BLK/ACTIVE_Q)*BLK_WORDS words, which is 8 by default. `full` is 1 exactly when the queue selected by `wr_q` holds that many words.
- R3: Words leave a queue in the order they were written. Traffic on one queue never changes the contents of another queue.
- R4: `rd_data`/`rd_valid` show the head of the queue selected by `rd_q` in the same cycle. A word written to an empty queue at a clock edge is valid in the cycle that follows that edge.
- R5: A write to a full queue stores nothing and moves no pointer, and `wr_rej` is 1 in the next cycle. The exception is a write made while a read of the same queue is accepted in the same cycle; that write is accepted.
- R6: A read from an empty queue changes nothing, and `rd_rej` is 1 in the next cycle. An accepted read leaves `rd_rej` at 0.
- R7: When a read and a write are both accepted on one queue in one cycle, its word count stays the same. In particular, a full queue stays full.
- R8: `almost_full` is 1 when the free space of the write-selected queue is at or below AF_OFF (default 2). `almost_empty` is 1 when the word count of the read-selected queue is at or below AE_OFF (default 1).
- R9: When `clr_en`=1, the queue named by `clr_q` is emptied at the clock edge. A write or read aimed at that queue in the same cycle is dropped without a reject flag. All other queues are unchanged.
- R10: With `poll_mode`=0, the group on each port is set directly. `wr_grp` equals `wr_grp_sel`, and `wr_stat` bit i is the almost-full flag of queue 8*`wr_grp_sel`+i. Likewise, `rd_grp` equals `rd_grp_sel`, and `rd_stat` bit i is the almost-empty flag of queue 8*`rd_grp_sel`+i.
- R11: With `poll_mode`=1, `wr_grp` and `rd_grp` both show a step counter, and the status buses show that counter's group. The counter advances by one at each clock edge, returns to 0 after group ceil(ACTIVE_Q/8)-1, and holds its value while `poll_mode`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_q | input | 5 | Queue selected for writing |
| wr_data | input | DW | Word to store |
| full | output | 1 | Write-selected queue is full |
| almost_full | output | 1 | Write-selected queue free space at or below AF_OFF |
| wr_rej | output | 1 | Write of the previous cycle was rejected |
| rd_en | input | 1 | Read request (consumes the shown head word) |
| rd_q | input | 5 | Queue selected for reading |
| rd_data | output | DW | Head word of the read-selected queue |
| rd_valid | output | 1 | Read-selected queue holds a word |
| almost_empty | output | 1 | Read-selected queue count at or below AE_OFF |
| rd_rej | output | 1 | Read of the previous cycle was rejected |
| clr_en | input | 1 | Clear one queue |
| clr_q | input | 5 | Queue to clear |
| poll_mode | input | 1 | 1: stepped group, 0: addressed group |
| wr_grp_sel | input | 2 | Addressed group for the write status bus |
| wr_stat | output | 8 | Almost-full flags of the shown group |
| wr_grp | output | 2 | Group shown on the write status bus |
| rd_grp_sel | input | 2 | Addressed group for the read status bus |
| rd_stat | output | 8 | Almost-empty flags of the shown group |
| rd_grp | output | 2 | Group shown on the read status bus |

## Verification
The head word, the valid and full flags, both almost flags and the direct-mode status buses are combinational on the select inputs and the stored state. The bench therefore samples them in the same cycle the selects are driven, half a nanosecond after driving. The two reject flags are registered and become valid one edge after the attempt, so the bench samples them half a nanosecond after the following rising edge. The bench expects a new head word or changed flags after an accepted access one edge later, and checks that the polled group steps once per edge.

// File: rtl/mq_pkg.sv
package mq_pkg;
    localparam int MAX_Q = 32;
    localparam int QAW   = 5;
    localparam int GRP   = 8;
    localparam int GBW   = $clog2(GRP);
    localparam int GAW   = QAW - GBW;

    typedef enum logic {
        GRP_DIRECT = 1'b0,
        GRP_POLL   = 1'b1
    } grp_mode_e;

    function automatic logic [MAX_Q-1:0] exist_mask(int n);
        logic [MAX_Q-1:0] m;
        m = '0;
        for (int i = 0; i < MAX_Q; i++) begin
            if (i < n) m[i] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/mq_store.sv
module mq_store #(
    parameter int DW    = 18,
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/mq_ctrl.sv
module mq_ctrl import mq_pkg::*; #(
    parameter int ACTIVE_Q = 32,
    parameter int QWORDS   = 8,
    parameter int AW       = 8,
    localparam int PW      = (QWORDS > 1) ? $clog2(QWORDS) : 1,
    localparam int CW      = $clog2(QWORDS + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [QAW-1:0]            wr_q,
    input  logic                      rd_en,
    input  logic [QAW-1:0]            rd_q,
    input  logic                      clr_en,
    input  logic [QAW-1:0]            clr_q,
    output logic                      mem_we,
    output logic [AW-1:0]             mem_waddr,
    output logic [AW-1:0]             mem_raddr,
    output logic [MAX_Q-1:0][CW-1:0]  cnt,
    output logic                      wr_rej,
    output logic                      rd_rej
);
    localparam logic [MAX_Q-1:0] QEXIST = exist_mask(ACTIVE_Q);

    typedef struct packed {
        logic [MAX_Q-1:0][PW-1:0] wp;
        logic [MAX_Q-1:0][PW-1:0] rp;
        logic [MAX_Q-1:0][CW-1:0] cnt;
        logic                     wrej;
        logic                     rrej;
    } st_t;

    st_t st_q, st_d;
    logic wr_clr, rd_clr, same, rd_ok, wr_ok;

    function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
        return (int'(p) == QWORDS - 1) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        st_d      = st_q;
        wr_clr    = clr_en && (clr_q == wr_q);
        rd_clr    = clr_en && (clr_q == rd_q);
        same      = (wr_q == rd_q);
        rd_ok     = rd_en && QEXIST[rd_q] && !rd_clr && (st_q.cnt[rd_q] != '0);
        wr_ok     = wr_en && QEXIST[wr_q] && !wr_clr &&
                    ((st_q.cnt[wr_q] != CW'(QWORDS)) || (rd_ok && same));
        st_d.wrej = wr_en && !wr_clr && !wr_ok;
        st_d.rrej = rd_en && !rd_clr && !rd_ok;
        if (wr_ok) begin
            st_d.wp[wr_q] = bump(st_q.wp[wr_q]);
            if (!(rd_ok && same)) st_d.cnt[wr_q] = st_q.cnt[wr_q] + 1'b1;
        end
        if (rd_ok) begin
            st_d.rp[rd_q] = bump(st_q.rp[rd_q]);
            if (!(wr_ok && same)) st_d.cnt[rd_q] = st_q.cnt[rd_q] - 1'b1;
        end
        if (clr_en && QEXIST[clr_q]) begin
            st_d.wp[clr_q]  = '0;
            st_d.rp[clr_q]  = '0;
            st_d.cnt[clr_q] = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_we    = wr_ok;
    assign mem_waddr = AW'(int'(wr_q) * QWORDS + int'(st_q.wp[wr_q]));
    assign mem_raddr = AW'(int'(rd_q) * QWORDS + int'(st_q.rp[rd_q]));
    assign cnt       = st_q.cnt;
    assign wr_rej    = st_q.wrej;
    assign rd_rej    = st_q.rrej;
endmodule

// File: rtl/mq_stat.sv
module mq_stat import mq_pkg::*; #(
    parameter int NGRP = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MAX_Q-1:0] flags,
    input  logic             poll_mode,
    input  logic [GAW-1:0]   grp_sel,
    output logic [GRP-1:0]   stat,
    output logic [GAW-1:0]   grp
);
    typedef struct packed {
        logic [GAW-1:0] poll;
    } st_t;

    st_t       st_q, st_d;
    grp_mode_e mode;

    assign mode = grp_mode_e'(poll_mode);

    always_comb begin
        st_d = st_q;
        if (mode == GRP_POLL) begin
            st_d.poll = (int'(st_q.poll) == NGRP - 1) ? '0 : st_q.poll + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign grp = (mode == GRP_POLL) ? st_q.poll : grp_sel;

    for (genvar i = 0; i < GRP; i++) begin : g_bit
        assign stat[i] = flags[{grp, GBW'(i)}];
    end
endmodule

// File: rtl/mq_fifo.sv
module mq_fifo import mq_pkg::*; #(
    parameter int DW        = 18,
    parameter int BLK_WORDS = 8,
    parameter int TOTAL_BLK = 32,
    parameter int ACTIVE_Q  = 32,
    parameter int AF_OFF    = 2,
    parameter int AE_OFF    = 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [QAW-1:0] wr_q,
    input  logic [DW-1:0]  wr_data,
    output logic           full,
    output logic           almost_full,
    output logic           wr_rej,
    input  logic           rd_en,
    input  logic [QAW-1:0] rd_q,
    output logic [DW-1:0]  rd_data,
    output logic           rd_valid,
    output logic           almost_empty,
    output logic           rd_rej,
    input  logic           clr_en,
    input  logic [QAW-1:0] clr_q,
    input  logic           poll_mode,
    input  logic [GAW-1:0] wr_grp_sel,
    output logic [GRP-1:0] wr_stat,
    output logic [GAW-1:0] wr_grp,
    input  logic [GAW-1:0] rd_grp_sel,
    output logic [GRP-1:0] rd_stat,
    output logic [GAW-1:0] rd_grp
);
    localparam int QBLK   = TOTAL_BLK / ACTIVE_Q;
    localparam int QWORDS = QBLK * BLK_WORDS;
    localparam int DEPTH  = TOTAL_BLK * BLK_WORDS;
    localparam int AW     = $clog2(DEPTH);
    localparam int CW     = $clog2(QWORDS + 1);
    localparam int NGRP   = (ACTIVE_Q + GRP - 1) / GRP;
    localparam logic [MAX_Q-1:0] QEXIST = exist_mask(ACTIVE_Q);

    logic                     mem_we;
    logic [AW-1:0]            mem_waddr, mem_raddr;
    logic [MAX_Q-1:0][CW-1:0] cnt;
    logic [MAX_Q-1:0]         af_v, ae_v;

    mq_ctrl #(.ACTIVE_Q(ACTIVE_Q), .QWORDS(QWORDS), .AW(AW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_q(wr_q), .rd_en(rd_en), .rd_q(rd_q),
        .clr_en(clr_en), .clr_q(clr_q),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_raddr(mem_raddr),
        .cnt(cnt), .wr_rej(wr_rej), .rd_rej(rd_rej)
    );

    mq_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(wr_data),
        .raddr(mem_raddr), .rdata(rd_data)
    );

    for (genvar q = 0; q < MAX_Q; q++) begin : g_flag
        assign af_v[q] = QEXIST[q] && ((QWORDS - int'(cnt[q])) <= AF_OFF);
        assign ae_v[q] = QEXIST[q] && (int'(cnt[q]) <= AE_OFF);
    end

    assign full         = (cnt[wr_q] == CW'(QWORDS));
    assign almost_full  = af_v[wr_q];
    assign rd_valid     = (cnt[rd_q] != '0);
    assign almost_empty = ae_v[rd_q];

    mq_stat #(.NGRP(NGRP)) u_wstat (
        .clk(clk), .rst_n(rst_n), .flags(af_v), .poll_mode(poll_mode),
        .grp_sel(wr_grp_sel), .stat(wr_stat), .grp(wr_grp)
    );

    mq_stat #(.NGRP(NGRP)) u_rstat (
        .clk(clk), .rst_n(rst_n), .flags(ae_v), .poll_mode(poll_mode),
        .grp_sel(rd_grp_sel), .stat(rd_stat), .grp(rd_grp)
    );
endmodule

// File: rtl/mq_fifo_chk.sv
module mq_fifo_chk import mq_pkg::*; #(
    parameter int NGRP = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           wr_en,
    input logic [QAW-1:0] wr_q,
    input logic           full,
    input logic           almost_full,
    input logic           wr_rej,
    input logic           rd_en,
    input logic [QAW-1:0] rd_q,
    input logic           rd_valid,
    input logic           rd_rej,
    input logic           clr_en,
    input logic [QAW-1:0] clr_q,
    input logic           poll_mode,
    input logic [GAW-1:0] wr_grp,
    input logic [GAW-1:0] rd_grp
);
    assert_full_rejects_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && full && !(clr_en && clr_q == wr_q) && !(rd_en && rd_valid && rd_q == wr_q)
        |=> wr_rej);

    assert_empty_rejects_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !rd_valid && !(clr_en && clr_q == rd_q) |=> rd_rej);

    assert_read_accepted_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && rd_valid && !(clr_en && clr_q == rd_q) |=> !rd_rej);

    assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_en) && (rd_q == $past(clr_q)) |-> !rd_valid);

    assert_full_is_almost_R8: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> almost_full);

    assert_poll_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        poll_mode && $past(poll_mode) && (int'($past(wr_grp)) != NGRP - 1)
        |-> wr_grp == $past(wr_grp) + 1'b1);

    assert_poll_lockstep_R11: assert property (@(posedge clk) disable iff (!rst_n)
        poll_mode |-> wr_grp == rd_grp);
endmodule

bind mq_fifo mq_fifo_chk #(.NGRP(NGRP)) u_chk (.*);

// File: tb/mq_fifo_bench.sv
`timescale 1ns/1ps
module mq_fifo_bench;
    localparam int DW = 18;
    localparam int QWORDS = 8;
    localparam int AF_OFF = 2;
    localparam int AE_OFF = 1;

    logic clk, rst_n;
    logic wr_en, rd_en, clr_en, poll_mode;
    logic [4:0] wr_q, rd_q, clr_q;
    logic [DW-1:0] wr_data, rd_data;
    logic full, almost_full, wr_rej, rd_valid, almost_empty, rd_rej;
    logic [1:0] wr_grp_sel, rd_grp_sel, wr_grp, rd_grp;
    logic [7:0] wr_stat, rd_stat;

    mq_fifo u_mq_fifo (.*);

    int nchk = 0, nfail = 0;
    logic [DW-1:0] mdat [32][QWORDS];
    int mw [32], mr [32], mc [32];
    int pg = 0;

    initial clk = 1'b0;
    always #2 clk = ~clk;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic bit m_af(int q);
        return (QWORDS - mc[q]) <= AF_OFF;
    endfunction

    function automatic bit m_ae(int q);
        return mc[q] <= AE_OFF;
    endfunction

    function automatic logic [7:0] m_stat(bit af, int g);
        logic [7:0] s;
        for (int i = 0; i < 8; i++) s[i] = af ? m_af(g * 8 + i) : m_ae(g * 8 + i);
        return s;
    endfunction

    // one cycle of traffic, entered and left at a falling edge
    task automatic cyc(bit we, int wq, logic [DW-1:0] wd, bit re, int rq, bit ce, int cq);
        bit rok, wok, erw, err;
        wr_en = we; wr_q = 5'(wq); wr_data = wd;
        rd_en = re; rd_q = 5'(rq); clr_en = ce; clr_q = 5'(cq);
        poll_mode = 1'b0;
        wr_grp_sel = 2'($urandom % 4); rd_grp_sel = 2'($urandom % 4);
        #0.5;
        chk("R2", "full", 32'(full), 32'(mc[wq] == QWORDS));
        chk("R8", "almost_full", 32'(almost_full), 32'(m_af(wq)));
        chk("R8", "almost_empty", 32'(almost_empty), 32'(m_ae(rq)));
        chk("R4", "rd_valid", 32'(rd_valid), 32'(mc[rq] != 0));
        if (mc[rq] != 0) chk("R3", "rd_data", 32'(rd_data), 32'(mdat[rq][mr[rq]]));
        chk("R10", "wr_stat", 32'(wr_stat), 32'(m_stat(1'b1, int'(wr_grp_sel))));
        chk("R10", "rd_stat", 32'(rd_stat), 32'(m_stat(1'b0, int'(rd_grp_sel))));
        chk("R10", "wr_grp", 32'(wr_grp), 32'(wr_grp_sel));
        rok = re && !(ce && cq == rq) && mc[rq] != 0;
        wok = we && !(ce && cq == wq) && (mc[wq] != QWORDS || (rok && rq == wq));
        erw = we && !(ce && cq == wq) && !wok;
        err = re && !(ce && cq == rq) && !rok;
        if (wok) begin
            mdat[wq][mw[wq]] = wd;
            mw[wq] = (mw[wq] + 1) % QWORDS;
            mc[wq]++;
        end
        if (rok) begin
            mr[rq] = (mr[rq] + 1) % QWORDS;
            mc[rq]--;
        end
        if (ce) begin
            mw[cq] = 0; mr[cq] = 0; mc[cq] = 0;
        end
        @(posedge clk);
        #0.5;
        chk("R5", "wr_rej", 32'(wr_rej), 32'(erw));
        chk("R6", "rd_rej", 32'(rd_rej), 32'(err));
        @(negedge clk);
    endtask

    task automatic idle_sel(int wq, int rq);
        wr_en = 0; rd_en = 0; clr_en = 0;
        wr_q = 5'(wq); rd_q = 5'(rq);
        #0.5;
    endtask

    task automatic poll(int n);
        for (int k = 0; k < n; k++) begin
            wr_en = 0; rd_en = 0; clr_en = 0; poll_mode = 1'b1;
            #0.5;
            chk("R11", "wr_grp", 32'(wr_grp), 32'(pg));
            chk("R11", "rd_grp", 32'(rd_grp), 32'(pg));
            chk("R11", "wr_stat", 32'(wr_stat), 32'(m_stat(1'b1, pg)));
            chk("R11", "rd_stat", 32'(rd_stat), 32'(m_stat(1'b0, pg)));
            @(posedge clk);
            pg = (pg + 1) % 4;
            @(negedge clk);
        end
        poll_mode = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int q = 0; q < 32; q++) begin mw[q] = 0; mr[q] = 0; mc[q] = 0; end
        rst_n = 0; wr_en = 0; rd_en = 0; clr_en = 0; poll_mode = 0;
        wr_q = 0; rd_q = 0; clr_q = 0; wr_data = 0; wr_grp_sel = 0; rd_grp_sel = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #0.1;
        // R1: reset state of every queue
        for (int q = 0; q < 32; q++) begin
            wr_q = 5'(q); rd_q = 5'(q);
            #0.01;
            chk("R1", "rd_valid", 32'(rd_valid), 0);
            chk("R1", "full", 32'(full), 0);
            chk("R1", "almost_empty", 32'(almost_empty), 1);
        end
        chk("R1", "wr_rej", 32'(wr_rej), 0);
        chk("R1", "rd_rej", 32'(rd_rej), 0);
        poll_mode = 1; #0.01;
        chk("R1", "wr_grp", 32'(wr_grp), 0);
        chk("R1", "rd_grp", 32'(rd_grp), 0);
        poll_mode = 0;
        @(negedge clk);

        // R2 / R5: fill queue 5, then overfill
        for (int i = 0; i < QWORDS; i++) cyc(1, 5, 18'(16'h500 + i), 0, 0, 0, 0);
        idle_sel(5, 5);
        chk("R2", "full at capacity", 32'(full), 1);
        cyc(1, 5, 18'h3ffff, 0, 0, 0, 0);
        idle_sel(5, 5);
        chk("R5", "head after rejected write", 32'(rd_data), 32'h500);
        // R7: read and write together on the full queue
        cyc(1, 5, 18'h1234, 1, 5, 0, 0);
        idle_sel(5, 5);
        chk("R7", "full kept", 32'(full), 1);
        chk("R7", "next head", 32'(rd_data), 32'h501);
        // R3 / R6: drain in order, then read empty
        for (int i = 0; i < QWORDS; i++) cyc(0, 0, 0, 1, 5, 0, 0);
        cyc(0, 0, 0, 1, 5, 0, 0);
        idle_sel(5, 5);
        chk("R6", "empty after drain", 32'(rd_valid), 0);

        // R4: fall-through one cycle after a write to an empty queue
        cyc(1, 7, 18'h2a, 0, 7, 0, 0);
        idle_sel(7, 7);
        chk("R4", "valid after write", 32'(rd_valid), 1);
        chk("R4", "data after write", 32'(rd_data), 32'h2a);
        cyc(1, 9, 18'h99, 1, 9, 0, 0);

        // R9: clear queue 2 while queue 3 holds data
        for (int i = 0; i < 3; i++) cyc(1, 2, 18'(16'h200 + i), 0, 0, 0, 0);
        for (int i = 0; i < 2; i++) cyc(1, 3, 18'(16'h300 + i), 0, 0, 0, 0);
        cyc(1, 2, 18'h2ff, 1, 2, 1, 2);
        idle_sel(2, 2);
        chk("R9", "cleared queue empty", 32'(rd_valid), 0);
        idle_sel(3, 3);
        chk("R9", "other queue valid", 32'(rd_valid), 1);
        chk("R9", "other queue head", 32'(rd_data), 32'h300);
        @(negedge clk);

        // R11: stepped group
        poll(10);

        // random traffic over a few busy queues
        for (int n = 0; n < 3000; n++) begin
            int wq, rq, cq;
            wq = ($urandom % 4 != 0) ? int'($urandom % 4) : int'($urandom % 32);
            rq = ($urandom % 4 != 0) ? int'($urandom % 4) : int'($urandom % 32);
            cq = int'($urandom % 32);
            cyc(($urandom % 10) < 6, wq, 18'($urandom), ($urandom % 2) == 1, rq,
                ($urandom % 50) == 0, cq);
        end

        // R11: counter held while direct, resumes
        poll(6);
        finish_run();
    end
endmodule